// File: doc/BRIEF.md
# Demand-Paced DMA Beat Engine

This block drives the local-bus side of one DMA channel. After a start pulse it moves a programmed number of 32-bit words as a series of bus beats. Each word takes four beats on an 8-bit bus, two beats on a 16-bit bus and one beat on a 32-bit bus. In demand mode a peripheral paces the transfer with a request line, and each beat that answers the request is acknowledged. With demand mode off, the words are streamed back to back and the request line plays no part.

A transfer can also be ended early by an end-of-transfer input, but only while that input is enabled. In the clean (slow) ending, an early stop still runs to an alignment point: the end of the current 32-bit word in single-beat operation, or the next 16-byte line in burst operation. While a slow burst is running, a burst-in-progress output is held high, and the run stops at the line edge. In the abrupt (fast) ending, either an end-of-transfer or a withdrawn request stops the run in the same cycle, with no beat, and the burst-in-progress output stays low. Every ending raises a one-cycle done pulse. The remaining byte count stays readable, so software can see how far a cut-short transfer got.

Top module: `dmd_xfer_engine`

## Requirements
- R1: After reset, busy, beat, beat_last, dack, burst_act and done are 0, and remain is 0.
- R2: The cfg_width code sets the beat size: 0 means 8-bit (1 byte per beat, 4 beats per word), 1 means 16-bit (2 bytes), and 2 or 3 means 32-bit (4 bytes). remain starts at count_in×4 bytes and drops by the beat size after each beat. remain shows the value before the beat during the beat cycle.
- R3: With cfg_demand=1, a beat happens only in a cycle where dreq is 1, and dack is 1 exactly in the cycles that carry a beat.
- R4: With cfg_demand=0, beats are issued in every running cycle regardless of dreq, and dack stays 0.
- R5: The beat that brings remain to 0 has beat_last=1. In the next cycle done is 1 for one cycle and busy is 0.
- R6: With cfg_eot_en=0, the eot input has no effect on beats, remain or done.
- R7: In slow mode (cfg_fast=0) without burst, an enabled eot is remembered. Beats continue to the end of the current 32-bit word, and that beat carries beat_last. If the transfer is already on a word edge, it ends at once with no beat.
- R8: In slow mode with cfg_burst=1, burst_act is 1 while busy. An enabled eot lets the transfer run to the next 16-byte boundary counted from the start, and the beat reaching it carries beat_last.
- R9: In fast mode (cfg_fast=1), an enabled eot, or dreq=0 while cfg_demand=1, during a busy cycle gives no beat in that cycle. done follows in the next cycle, and remain keeps the untransferred byte count.
- R10: In fast mode, burst_act stays 0.
- R11: A start while busy is ignored. A start with count_in=0 gives a done pulse in the next cycle with no beat and remain 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_demand | input | 1 | 1 = pace beats by dreq |
| cfg_eot_en | input | 1 | 1 = honour eot |
| cfg_fast | input | 1 | 1 = abrupt ending, 0 = clean ending |
| cfg_burst | input | 1 | 1 = burst operation (16-byte stop points) |
| cfg_width | input | 2 | Bus width code: 0 = 8, 1 = 16, 2/3 = 32 bits |
| count_in | input | CNT_W | Transfer length in 32-bit words |
| start | input | 1 | Start pulse, taken only when idle |
| dreq | input | 1 | Demand request |
| eot | input | 1 | End-of-transfer request |
| beat | output | 1 | One bus beat this cycle |
| beat_last | output | 1 | This beat is the final one |
| dack | output | 1 | Acknowledge for a demand-served beat |
| burst_act | output | 1 | Burst in progress |
| busy | output | 1 | Transfer running |
| done | output | 1 | One-cycle pulse after the transfer ends |
| remain | output | CNT_W+2 | Bytes not yet transferred |

## Verification
The assertions assume that the configuration inputs stay fixed while busy is high and that reset is applied before the first start. The bench changes the configuration only between transfers, after done has been seen and the engine is idle. dreq and eot are driven just after the clock edge and held for a whole cycle, so every combinational beat decision sees stable inputs. The property about eot having no effect is stated only for free-running transfers, where nothing else can hold back a beat, and the stimulus includes exactly that case.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

  typedef enum logic [1:0] {
    BW8  = 2'd0,
    BW16 = 2'd1,
    BW32 = 2'd2
  } bus_w_e;

  // Bytes moved by one beat for a given width code (code 3 behaves as 32-bit).
  function automatic logic [2:0] beat_bytes(input logic [1:0] w);
    case (w)
      BW8:     return 3'd1;
      BW16:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // True when a byte offset sits on an edge of a power-of-two span.
  function automatic logic on_bnd(input logic [7:0] off, input logic [7:0] span);
    return (off & (span - 8'd1)) == 8'd0;
  endfunction

endpackage

// File: rtl/dmd_beat_track.sv
module dmd_beat_track #(
  parameter int REM_W = 18,
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REM_W-1:0] load_bytes,
  input  logic             step,
  input  logic [2:0]       step_bytes,
  output logic [REM_W-1:0] remain,
  output logic [OFF_W-1:0] off
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      off    <= '0;
    end else if (load) begin
      remain <= load_bytes;
      off    <= '0;
    end else if (step) begin
      remain <= remain - REM_W'(step_bytes);
      off    <= off + OFF_W'(step_bytes);
    end
  end

endmodule

// File: rtl/dmd_term_ctrl.sv
module dmd_term_ctrl
  import dmd_pkg::*;
#(
  parameter int REM_W       = 18,
  parameter int OFF_W       = 4,
  parameter int BURST_BYTES = 16
) (
  input  logic             run,
  input  logic             demand,
  input  logic             eot_en,
  input  logic             fast,
  input  logic             burst,
  input  logic             dreq,
  input  logic             eot,
  input  logic             pend,
  input  logic [REM_W-1:0] remain,
  input  logic [OFF_W-1:0] off,
  input  logic [2:0]       bsz,
  output logic             beat,
  output logic             beat_last,
  output logic             cut,
  output logic             eot_seen
);

  localparam logic [7:0] BURST_SPAN = 8'(BURST_BYTES);
  localparam logic [7:0] WORD_SPAN  = 8'd4;

  logic [7:0] span;
  logic       stop_req;
  logic       fast_cut;
  logic       slow_cut;
  logic       at_end;

  always_comb begin
    span      = burst ? BURST_SPAN : WORD_SPAN;
    eot_seen  = eot_en && eot;
    stop_req  = pend || eot_seen;
    fast_cut  = fast && (eot_seen || (demand && !dreq));
    slow_cut  = !fast && stop_req && on_bnd(8'(off), span);
    cut       = run && (fast_cut || slow_cut);
    beat      = run && !(fast_cut || slow_cut) && (!demand || dreq);
    at_end    = remain == REM_W'(bsz);
    beat_last = beat && (at_end ||
                (!fast && stop_req && on_bnd(8'(off) + 8'(bsz), span)));
  end

endmodule

// File: rtl/dmd_xfer_engine.sv
module dmd_xfer_engine
  import dmd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_demand,
  input  logic             cfg_eot_en,
  input  logic             cfg_fast,
  input  logic             cfg_burst,
  input  logic [1:0]       cfg_width,
  input  logic [CNT_W-1:0] count_in,
  input  logic             start,
  input  logic             dreq,
  input  logic             eot,
  output logic             beat,
  output logic             beat_last,
  output logic             dack,
  output logic             burst_act,
  output logic             busy,
  output logic             done,
  output logic [CNT_W+1:0] remain
);

  localparam int REM_W = CNT_W + 2;
  localparam int OFF_W = $clog2(BURST_BYTES);

  logic             run_q;
  logic             pend_q;
  logic             done_q;
  logic [2:0]       bsz;
  logic             start_ok;
  logic             term_cut;
  logic             eot_seen;
  logic             finish;
  logic [OFF_W-1:0] off;

  assign bsz      = beat_bytes(cfg_width);
  assign start_ok = start && !run_q;
  assign finish   = term_cut || beat_last;

  dmd_beat_track #(.REM_W(REM_W), .OFF_W(OFF_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .load_bytes({count_in, 2'b00}),
    .step      (beat),
    .step_bytes(bsz),
    .remain    (remain),
    .off       (off)
  );

  dmd_term_ctrl #(.REM_W(REM_W), .OFF_W(OFF_W), .BURST_BYTES(BURST_BYTES)) u_term (
    .run      (run_q),
    .demand   (cfg_demand),
    .eot_en   (cfg_eot_en),
    .fast     (cfg_fast),
    .burst    (cfg_burst),
    .dreq     (dreq),
    .eot      (eot),
    .pend     (pend_q),
    .remain   (remain),
    .off      (off),
    .bsz      (bsz),
    .beat     (beat),
    .beat_last(beat_last),
    .cut      (term_cut),
    .eot_seen (eot_seen)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (start_ok && count_in == '0) || finish;
      if (start_ok) begin
        run_q  <= count_in != '0;
        pend_q <= 1'b0;
      end else if (finish) begin
        run_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (run_q && !cfg_fast && eot_seen) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign busy      = run_q;
  assign done      = done_q;
  assign dack      = beat && cfg_demand;
  assign burst_act = run_q && cfg_burst && !cfg_fast;

endmodule

// File: rtl/dmd_xfer_chk.sv
module dmd_xfer_chk #(
  parameter int REM_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_demand,
  input logic             cfg_eot_en,
  input logic             cfg_fast,
  input logic             dreq,
  input logic             beat,
  input logic             beat_last,
  input logic             dack,
  input logic             burst_act,
  input logic             busy,
  input logic             done,
  input logic             cut,
  input logic [REM_W-1:0] remain
);

  assert_dack_needs_dreq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (dreq && cfg_demand && beat));

  assert_no_dack_free_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_demand |-> !dack);

  assert_last_is_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat);

  assert_last_then_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> (done && !busy));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_eot_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_eot_en && !cfg_demand) |-> beat);

  assert_fast_cut_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_fast && cfg_demand && !dreq) |-> (!beat && cut));

  assert_fast_cut_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_fast && cfg_demand && !dreq) |=> done);

  assert_hold_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat) |=> $stable(remain));

  assert_burst_quiet_fast_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fast |-> !burst_act);

endmodule

bind dmd_xfer_engine dmd_xfer_chk #(.REM_W(CNT_W + 2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_demand(cfg_demand),
  .cfg_eot_en(cfg_eot_en),
  .cfg_fast  (cfg_fast),
  .dreq      (dreq),
  .beat      (beat),
  .beat_last (beat_last),
  .dack      (dack),
  .burst_act (burst_act),
  .busy      (busy),
  .done      (done),
  .cut       (term_cut),
  .remain    (remain)
);

// File: tb/test_dmd_xfer_engine.sv
module test_dmd_xfer_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_demand = 0, cfg_eot_en = 0, cfg_fast = 0, cfg_burst = 0;
  logic [1:0]  cfg_width = 2'd0;
  logic [15:0] count_in = '0;
  logic        start = 0, dreq = 0, eot = 0;
  logic        beat, beat_last, dack, burst_act, busy, done;
  logic [17:0] remain;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  bit mon_on = 0;
  string cur_tag = "R1";
  logic [18:0] exp_q[$];

  always #10 clk = ~clk;

  dmd_xfer_engine i_dmd_xfer_engine (
    .clk(clk), .rst_n(rst_n), .cfg_demand(cfg_demand), .cfg_eot_en(cfg_eot_en),
    .cfg_fast(cfg_fast), .cfg_burst(cfg_burst), .cfg_width(cfg_width),
    .count_in(count_in), .start(start), .dreq(dreq), .eot(eot),
    .beat(beat), .beat_last(beat_last), .dack(dack), .burst_act(burst_act),
    .busy(busy), .done(done), .remain(remain)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: pops expected beats and checks acknowledge and burst flags.
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      check(dack == (beat && cfg_demand), cur_tag, "dack", dack, beat && cfg_demand);
      check(burst_act == (busy && cfg_burst && !cfg_fast), cur_tag, "burst_act",
            burst_act, busy && cfg_burst && !cfg_fast);
      if (done) begin
        done_cnt++;
        check(!busy, cur_tag, "busy during done", busy, 0);
      end
      if (beat) begin
        if (exp_q.size() == 0) begin
          check(0, cur_tag, "unexpected beat, remain", remain, 0);
        end else begin
          logic [18:0] it;
          it = exp_q.pop_front();
          check(remain == it[17:0], cur_tag, "remain at beat", remain, it[17:0]);
          check(beat_last == it[18], cur_tag, "beat_last", beat_last, it[18]);
        end
      end
    end
  end

  // Driver: runs one transfer and pushes the beats the requirements predict.
  task automatic xfer(input string tag, input logic [1:0] w, input bit dem, input bit fast,
                      input bit burst, input bit eoten, input int cnt,
                      input logic [31:0] dmask, input int eot_at, input int restart_at);
    int brem, boff, bsz, span;
    bit pend, fin, eh, sr, last;
    cur_tag = tag;
    cfg_width = w; cfg_demand = dem; cfg_fast = fast; cfg_burst = burst; cfg_eot_en = eoten;
    done_cnt = 0;
    bsz = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    span = burst ? 16 : 4;
    brem = cnt * 4; boff = 0; pend = 0; fin = (cnt == 0);
    @(posedge clk); #2;
    start = 1; count_in = 16'(cnt);
    @(posedge clk); #2;
    start = 0;
    for (int k = 0; k < 300 && !fin; k++) begin
      dreq = dmask[k % 32];
      eot = (k == eot_at);
      start = (k == restart_at);
      if (k == restart_at) count_in = 16'd7;
      eh = eoten && eot;
      sr = pend || eh;
      if (fast && (eh || (dem && !dreq))) fin = 1;
      else if (!fast && sr && (boff % span) == 0) fin = 1;
      else if (!dem || dreq) begin
        last = (brem == bsz) || (!fast && sr && ((boff + bsz) % span) == 0);
        exp_q.push_back({last, 18'(brem)});
        brem -= bsz;
        boff = (boff + bsz) % 16;
        if (last) fin = 1;
      end
      if (!fast && eh) pend = 1;
      @(posedge clk); #2;
    end
    dreq = 0; eot = 0; start = 0;
    repeat (3) @(posedge clk);
    #3;
    check(exp_q.size() == 0, tag, "beats missing", exp_q.size(), 0);
    exp_q.delete();
    check(done_cnt == 1, tag, "done pulses", done_cnt, 1);
    check(remain == 18'(brem), tag, "final remain", remain, brem);
    check(!busy, tag, "busy after end", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    check(!busy && !beat && !beat_last && !dack && !burst_act && !done, "R1",
          "outputs in reset", {busy, beat, dack, done}, 0);
    check(remain == 0, "R1", "remain in reset", remain, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(!busy && !done && remain == 0, "R1", "idle after reset", busy, 0);
    mon_on = 1;
    // R2/R4: 8-bit free run, dreq held low and ignored
    xfer("R4", 2'd0, 0, 0, 0, 0, 2, 32'h0, -1, -1);
    // R3: 16-bit demand with gaps
    xfer("R3", 2'd1, 1, 0, 0, 0, 3, 32'hAAAA_AAAA, -1, -1);
    // R2: 32-bit demand, steady request
    xfer("R2", 2'd2, 1, 0, 0, 0, 4, 32'hFFFF_FFFF, -1, -1);
    // R6: eot pulses while disabled, fast mode
    xfer("R6", 2'd0, 0, 1, 0, 0, 2, 32'h0, 2, -1);
    // R7: slow single-beat eot mid-word
    xfer("R7", 2'd0, 1, 0, 0, 1, 3, 32'hFFFF_FFFF, 1, -1);
    // R7: slow eot landing on a word edge
    xfer("R7", 2'd2, 0, 0, 0, 1, 5, 32'h0, 2, -1);
    // R8: slow burst, stop at 16-byte line
    xfer("R8", 2'd1, 1, 0, 1, 1, 8, 32'hFFFF_FFFF, 3, -1);
    // R9: fast, request withdrawn
    xfer("R9", 2'd0, 1, 1, 0, 0, 4, 32'h0000_0007, -1, -1);
    // R9/R10: fast burst with eot
    xfer("R10", 2'd1, 1, 1, 1, 1, 6, 32'hFFFF_FFFF, 5, -1);
    // R5: count exhaustion in slow burst
    xfer("R5", 2'd3, 0, 0, 1, 1, 3, 32'h0, -1, -1);
    // R11: restart while busy is ignored, then zero-length start
    xfer("R11", 2'd2, 1, 0, 0, 0, 3, 32'hFFFF_FFFF, -1, 1);
    xfer("R11", 2'd0, 0, 0, 0, 0, 0, 32'h0, -1, -1);
    finish_run();
  end

endmodule